// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block holds a set of general-purpose timers, four by default, each with a 32-bit counter that decreases by one on every clock. It sits behind a small memory-mapped register port with separate read and write strobes, a byte address, write data and registered read data. A single bank-wide enable bit gates every channel at once. Each channel also has its own enable bit, reload word, wrap counter, interrupt status, clear and mask.

When a running channel reaches zero, it reloads on the next clock. At the same moment its wrap counter advances and its interrupt status is raised. A reload of all ones gives a free-running count over the full range, and software inverts it to obtain a rising time base.

The live count is not read directly. Reading a channel's wrap counter captures the count into a snapshot, and a later read of the count register returns that snapshot. Software therefore reads the wrap counter first, then the count, and gets a matched pair.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads 0 and every `irq` bit is 0. The exception is the revision word at 0x10, which always reads the `REV_ID` parameter.
- R2: Address map. Bank control is at 0x00, with bit 0 as the bank enable. The revision word is at 0x10. Channel n (0 to NCH-1) starts at base 0x20+0x20·n. Its registers are at these offsets from the base: enable +0x00 (bit 0), reload +0x04, count snapshot +0x08, wrap counter +0x0C, status +0x10 (bit 0), clear +0x14 (bit 0), mask +0x18 (bit 0). A read strobe in cycle t returns its data on `rdata` after edge t, and `rdata` holds between reads.
- R3: A channel's count changes only while both the bank enable and its own enable are 1. While it runs, the count drops by one per clock.
- R4: A write that sets a channel's enable while that enable is 0 loads the count with the channel's reload word.
- R5: On the clock after a running channel's count is 0, three things happen: the count takes the reload word, the wrap counter increments, and status bit 0 is set.
- R6: A read of the wrap counter copies the count, as it stood in that read's cycle, into the snapshot. Reads of the count register return the snapshot, which changes on no other event.
- R7: `irq[n]` is status AND mask of channel n. Writing 1 to bit 0 of clear resets status. If a wrap occurs in the same cycle as the clear, the wrap wins. Writing mask 0 silences the interrupt.
- R8: Writes to read-only words (revision, count, wrap counter, status) change nothing. Reads of unmapped addresses, including those not aligned to a word, return 0.
- R9: Channels are independent. Writes to one channel's words do not alter another channel's state or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W | Byte address of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | NCH | Per-channel interrupt, status AND mask |

## Verification
Every result is due a fixed number of edges after its stimulus. Read data appears after the edge that samples the read strobe. An enable or load takes effect at the edge of the write, and counting starts on the following edge. Wrap effects appear one edge after the count is zero. The bench numbers every rising edge and records the edge at which each write and read was sampled. It then computes the expected count and wrap total from the reload word and the edges elapsed since counting began. All ports are sampled on the falling edge after the relevant rising edge.

// File: rtl/tmrb_pkg.sv
package tmrb_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    SEL_CFG, SEL_RELOAD, SEL_CUR, SEL_OVF, SEL_STAT, SEL_CLR, SEL_MASK, SEL_NONE
  } chan_sel_e;

  // Offset of a word inside one channel's 32-byte window
  function automatic chan_sel_e decode_off(input logic [4:0] off);
    case (off)
      5'h00:   return SEL_CFG;
      5'h04:   return SEL_RELOAD;
      5'h08:   return SEL_CUR;
      5'h0C:   return SEL_OVF;
      5'h10:   return SEL_STAT;
      5'h14:   return SEL_CLR;
      5'h18:   return SEL_MASK;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tmrb_decode.sv
module tmrb_decode
  import tmrb_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              gctl_hit,
  output logic              rev_hit,
  output logic [NCH-1:0]    ch_hit,
  output chan_sel_e         sel
);
  localparam int BLK_W = ADDR_W - 5;

  logic [BLK_W-1:0] blk;
  logic [4:0]       off;

  assign blk      = addr[ADDR_W-1:5];
  assign off      = addr[4:0];
  assign sel      = decode_off(off);
  assign gctl_hit = (blk == '0) && (off == 5'h00);
  assign rev_hit  = (blk == '0) && (off == 5'h10);

  // Window 0 holds the bank words; channel i lives in window i+1
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_hit
      assign ch_hit[i] = (blk == BLK_W'(i + 1)) && (sel != SEL_NONE);
    end
  endgenerate
endmodule

// File: rtl/tmrb_chan.sv
module tmrb_chan
  import tmrb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen,
  input  logic              wr,
  input  logic              rd,
  input  chan_sel_e         sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word,
  output logic              irq_o
);
  logic             en, mask, status;
  logic [CNT_W-1:0] cnt, reload, ovf, snap;

  // Named events, shared by the logic and the assertions
  logic run, cfg_wr, mask_wr, load_evt, wrap_evt, clr_evt, snap_evt;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - CNT_W'(1);
  endfunction

  assign run      = gen & en;
  assign cfg_wr   = wr && (sel == SEL_CFG);
  assign mask_wr  = wr && (sel == SEL_MASK);
  assign load_evt = cfg_wr && wdata[0] && !en;
  assign wrap_evt = run && (cnt == '0);
  assign clr_evt  = wr && (sel == SEL_CLR) && wdata[0];
  assign snap_evt = rd && (sel == SEL_OVF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mask <= 1'b0; status <= 1'b0;
      cnt <= '0; reload <= '0; ovf <= '0; snap <= '0;
    end else begin
      if (cfg_wr)  en   <= wdata[0];
      if (mask_wr) mask <= wdata[0];
      if (wr && (sel == SEL_RELOAD)) reload <= wdata[CNT_W-1:0];
      if (load_evt)  cnt <= reload;
      else if (run)  cnt <= step_down(cnt, reload);
      if (wrap_evt)  ovf <= ovf + CNT_W'(1);
      if (wrap_evt)     status <= 1'b1;
      else if (clr_evt) status <= 1'b0;
      if (snap_evt)  snap <= cnt;
    end
  end

  assign irq_o = status & mask;

  always_comb begin
    case (sel)
      SEL_CFG:    rd_word = DATA_W'(en);
      SEL_RELOAD: rd_word = DATA_W'(reload);
      SEL_CUR:    rd_word = DATA_W'(snap);
      SEL_OVF:    rd_word = DATA_W'(ovf);
      SEL_STAT:   rd_word = DATA_W'(status);
      SEL_MASK:   rd_word = DATA_W'(mask);
      default:    rd_word = '0;
    endcase
  end

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && (cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !load_evt |=> $stable(cnt)); // R3
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> en && (cnt == $past(reload))); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> status && (cnt == $past(reload)) && (ovf == $past(ovf) + CNT_W'(1))); // R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_evt |=> $stable(snap)); // R6
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt && !wrap_evt |=> !irq_o); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && mask && !mask_wr |=> irq_o); // R7
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmrb_pkg::*;
#(
  parameter int          NCH    = 4,
  parameter int          CNT_W  = 32,
  parameter int          ADDR_W = 8,
  parameter logic [31:0] REV_ID = 32'h0001_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    irq
);
  logic                  gen;
  logic                  gctl_hit, rev_hit;
  logic [NCH-1:0]        ch_hit;
  chan_sel_e             sel;
  logic [DATA_W-1:0]     ch_word [NCH];
  logic [DATA_W-1:0]     rd_mux;

  tmrb_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .gctl_hit(gctl_hit), .rev_hit(rev_hit), .ch_hit(ch_hit), .sel(sel)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      tmrb_chan #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .gen(gen),
        .wr(wr_en && ch_hit[i]), .rd(rd_en && ch_hit[i]),
        .sel(sel), .wdata(wdata), .rd_word(ch_word[i]), .irq_o(irq[i])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (gctl_hit) rd_mux = DATA_W'(gen);
    if (rev_hit)  rd_mux = REV_ID;
    for (int i = 0; i < NCH; i++)
      if (ch_hit[i]) rd_mux = ch_word[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen   <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_en && gctl_hit) gen <= wdata[0];
      if (rd_en) rdata <= rd_mux;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> $onehot0({gctl_hit, rev_hit, ch_hit})); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2
endmodule

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;
  localparam int NCH = 4;
  localparam logic [31:0] REV = 32'h0001_0002;

  logic        clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq;
  int errs = 0, checks = 0;
  int unsigned cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_bank #(.NCH(NCH), .REV_ID(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int unsigned at);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk); wr_en = 1'b0; at = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output int unsigned at);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk); rd_en = 1'b0; d = rdata; at = cyc;
  endtask

  // Count left after d running edges from a load of rl
  function automatic logic [31:0] m_cnt(input longint unsigned rl, input longint unsigned d);
    return 32'(rl - (d % (rl + 1)));
  endfunction
  function automatic logic [31:0] m_wraps(input longint unsigned rl, input longint unsigned d);
    return 32'(d / (rl + 1));
  endfunction

  int unsigned g_on, t_dis, t_en, t3, tw;
  logic [31:0] v, v2;

  task automatic t_reset();
    rd(8'h00, v, tw); check("R1 ctrl", v, 0);
    rd(8'h20, v, tw); check("R1 cfg", v, 0);
    rd(8'h24, v, tw); check("R1 reload", v, 0);
    rd(8'h2C, v, tw); check("R1 ovf", v, 0);
    rd(8'h28, v, tw); check("R1 cur", v, 0);
    rd(8'h30, v, tw); check("R1 status", v, 0);
    rd(8'h10, v, tw); check("R1 rev", v, REV);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_gate();
    wr(8'h24, 32'd5, tw);
    wr(8'h20, 32'd1, tw);
    repeat (20) @(negedge clk);
    rd(8'h2C, v, tw);  check("R3 ovf gated", v, 0);
    rd(8'h28, v, tw);  check("R4 load on enable, R3 held", v, 32'd5);
    rd(8'h24, v, tw);  check("R2 reload readback", v, 32'd5);
    rd(8'h20, v, tw);  check("R2 cfg readback", v, 32'd1);
  endtask

  task automatic t_run();
    int unsigned r;
    wr(8'h00, 32'd1, g_on);
    rd(8'h00, v, tw); check("R2 ctrl readback", v, 1);
    repeat (40) @(negedge clk);
    rd(8'h2C, v, r);  check("R5 wraps", v, m_wraps(5, r - 1 - g_on));
    rd(8'h28, v2, tw); check("R6 R3 snapshot count", v2, m_cnt(5, r - 1 - g_on));
    rd(8'h30, v, tw); check("R5 status", v, 1);
    check("R7 masked irq", 32'(irq[0]), 0);
    // Snapshot must stay put until the next wrap-counter read
    repeat (9) @(negedge clk);
    rd(8'h28, v, tw); check("R6 snapshot held", v, v2);
    rd(8'h2C, v, r);
    rd(8'h28, v, tw); check("R6 snapshot refreshed", v, m_cnt(5, r - 1 - g_on));
  endtask

  task automatic t_irq();
    wr(8'h38, 32'd1, tw);
    check("R7 irq when masked in", 32'(irq[0]), 1);
    wr(8'h20, 32'd0, t_dis);
    wr(8'h34, 32'd1, tw);
    check("R7 irq after clear", 32'(irq[0]), 0);
    rd(8'h30, v, tw); check("R7 status cleared", v, 0);
    repeat (8) @(negedge clk);
    rd(8'h2C, v, tw); check("R3 ovf frozen", v, m_wraps(5, t_dis - g_on));
    rd(8'h28, v, tw); check("R3 count frozen", v, m_cnt(5, t_dis - g_on));
  endtask

  task automatic t_readonly();
    wr(8'h28, 32'hDEAD_BEEF, tw);
    wr(8'h2C, 32'h55, tw);
    wr(8'h30, 32'd1, tw);
    wr(8'h10, 32'h1234, tw);
    rd(8'h2C, v, tw); check("R8 ovf ignores write", v, m_wraps(5, t_dis - g_on));
    rd(8'h28, v, tw); check("R8 count ignores write", v, m_cnt(5, t_dis - g_on));
    rd(8'h30, v, tw); check("R8 status ignores write", v, 0);
    rd(8'h10, v, tw); check("R8 rev ignores write", v, REV);
    check("R8 irq unchanged", 32'(irq[0]), 0);
    rd(8'h1C, v, tw); check("R8 unmapped 0x1C", v, 0);
    rd(8'h3C, v, tw); check("R8 unmapped 0x3C", v, 0);
    rd(8'hA0, v, tw); check("R8 unmapped 0xA0", v, 0);
    rd(8'h22, v, tw); check("R8 unaligned 0x22", v, 0);
  endtask

  task automatic t_reenable();
    int unsigned r;
    wr(8'h24, 32'd3, tw);
    wr(8'h20, 32'd1, t_en);
    rd(8'h2C, v, r);  check("R4 ovf kept over re-enable", v, m_wraps(5, t_dis - g_on));
    rd(8'h28, v, tw); check("R4 reload on re-enable", v, m_cnt(3, r - 1 - t_en));
  endtask

  task automatic t_chan3();
    int unsigned r;
    wr(8'h84, 32'hFFFF_FFFF, tw);
    wr(8'h80, 32'd1, t3);
    repeat (7) @(negedge clk);
    rd(8'h8C, v, r);  check("R9 ch3 ovf", v, 0);
    rd(8'h88, v, tw); check("R9 ch3 full range count", v, 32'hFFFF_FFFF - (r - 1 - t3));
    rd(8'h24, v, tw); check("R9 ch0 reload untouched", v, 32'd3);
    check("R9 ch3 irq", 32'(irq[3]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate();
    t_run();
    t_irq();
    t_readonly();
    t_reenable();
    t_chan3();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule